// File: doc/BRIEF.md
# Variable-Latency Integer Execution Unit

This block is one integer execution lane. It takes one operation at a time over a valid/ready handshake. Each operation carries a 3-bit opcode, two data operands and a destination tag. The unit computes the result and returns it with the same tag and a one-cycle valid pulse once that opcode's latency has passed. The opcode sets the latency. Add, AND and signed compare finish in one cycle. Multiply takes six cycles and unsigned divide takes nineteen, and neither is pipelined.

The operand values are captured and the answer is computed at acceptance. The answer sits in a holding register while a down-counter runs out the remaining cycles. While the counter is non-zero the unit drops ready and so refuses further work. For this reason results always leave in the order their operations were accepted. A long divide shuts out all other traffic for its whole duration.

Top module: `int_exec_unit`

## Requirements
- R1: While reset (rst_n low, sampled on the clock) is applied and in the first cycle after it, out_valid is 0 and in_ready is 1.
- R2: Opcode 0 (add) returns (a + b) modulo 2^DATA_W. Its out_valid is high in the cycle that directly follows the accepting clock edge.
- R3: Opcode 1 (AND) returns the bitwise AND of a and b, with the one-cycle timing of R2.
- R4: Opcode 2 (compare) treats a and b as signed. It returns a code in result bits [2:0]: bit 2 means a<b, bit 1 means a>b, bit 0 means a==b. All upper bits are zero. The timing is that of R2.
- R5: Opcode 3 (multiply) returns the low DATA_W bits of a*b. Counting the accepting edge as edge 1, out_valid rises after edge MUL_LAT (6).
- R6: Opcode 4 (divide) returns the unsigned quotient a/b. Out_valid rises after edge DIV_LAT (19), counted as in R5.
- R7: A divide with b equal to 0 returns all ones, with the same DIV_LAT timing as R6. The unit then accepts work again.
- R8: After accepting a multiply or divide, in_ready is 0 in every cycle up to, but not including, the result cycle. In the result cycle in_ready is 1. Any in_valid asserted while in_ready is 0 is ignored and produces no result.
- R9: Every accepted operation produces exactly one out_valid pulse. Its out_tag equals that operation's tag, and results appear in acceptance order.
- R10: Opcodes 5 to 7 are accepted with one-cycle timing and return zero.
- R11: One-cycle operations can be accepted on consecutive clock edges. Each one yields its result in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can accept an operation this cycle |
| in_op | input | 3 | Opcode (0 add, 1 AND, 2 compare, 3 multiply, 4 divide) |
| in_a | input | DATA_W | First operand |
| in_b | input | DATA_W | Second operand |
| in_tag | input | TAG_W | Destination tag of the operation |
| out_valid | output | 1 | One-cycle result pulse |
| out_data | output | DATA_W | Result value |
| out_tag | output | TAG_W | Tag of the operation producing the result |

## Verification
The bench builds the unit with its defaults: 32-bit data, 5-bit tags, a 6-cycle multiply and a 19-cycle divide. With these values the full-width carry-out and signed-extreme compare cases are reachable, as is a multiply whose product overflows into the discarded upper half. The nineteen-cycle busy window can be probed on every cycle with junk requests, and the widest counter value is exercised on each divide. Random opcodes, including the unused codes, are interleaved with zero divisors and equal operands. Directed back-to-back runs show that the single-cycle path sustains one operation per clock.

// File: rtl/ieu_pkg.sv
package ieu_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_AND = 3'd1,
        OP_CMP = 3'd2,
        OP_MUL = 3'd3,
        OP_DIV = 3'd4
    } op_e;

    localparam int OP_W = 3;

endpackage

// File: rtl/ieu_alu.sv
module ieu_alu #(
    parameter int DATA_W = 32
) (
    input  logic [ieu_pkg::OP_W-1:0] op,
    input  logic [DATA_W-1:0]        a,
    input  logic [DATA_W-1:0]        b,
    output logic [DATA_W-1:0]        res
);
    import ieu_pkg::*;

    logic lt_s, gt_s, eq_s;

    always_comb begin
        lt_s = $signed(a) < $signed(b);
        gt_s = $signed(a) > $signed(b);
        eq_s = (a == b);
        res  = '0;
        case (op)
            OP_ADD:  res = a + b;
            OP_AND:  res = a & b;
            OP_CMP:  res = {{(DATA_W-3){1'b0}}, lt_s, gt_s, eq_s};
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/ieu_mul.sv
module ieu_mul #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] prod_lo
);
    localparam int FULL_W = 2 * DATA_W;

    logic [FULL_W-1:0] full;

    always_comb begin
        full    = {{DATA_W{1'b0}}, a} * {{DATA_W{1'b0}}, b};
        prod_lo = full[DATA_W-1:0];
    end

endmodule

// File: rtl/ieu_div.sv
module ieu_div #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] num,
    input  logic [DATA_W-1:0] den,
    output logic [DATA_W-1:0] quo
);
    logic den_zero;

    always_comb begin
        den_zero = (den == '0);
        if (den_zero) quo = '1;
        else          quo = num / den;
    end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit #(
    parameter int DATA_W  = 32,
    parameter int TAG_W   = 5,
    parameter int MUL_LAT = 6,
    parameter int DIV_LAT = 19
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [ieu_pkg::OP_W-1:0] in_op,
    input  logic [DATA_W-1:0]        in_a,
    input  logic [DATA_W-1:0]        in_b,
    input  logic [TAG_W-1:0]         in_tag,
    output logic                     out_valid,
    output logic [DATA_W-1:0]        out_data,
    output logic [TAG_W-1:0]         out_tag
);
    import ieu_pkg::*;

    localparam int MAX_LAT = (MUL_LAT > DIV_LAT) ? MUL_LAT : DIV_LAT;
    localparam int CNT_W   = $clog2(MAX_LAT + 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              vld;
        logic [DATA_W-1:0] res;
        logic [TAG_W-1:0]  tag;
    } state_t;

    state_t st_d, st_q;

    logic [DATA_W-1:0] alu_res, mul_res, div_res, sel_res;
    logic [CNT_W-1:0]  lat_sel;
    logic              accept;

    function automatic logic [CNT_W-1:0] lat_of(input logic [OP_W-1:0] op);
        case (op)
            OP_MUL:  lat_of = CNT_W'(MUL_LAT);
            OP_DIV:  lat_of = CNT_W'(DIV_LAT);
            default: lat_of = CNT_W'(1);
        endcase
    endfunction

    ieu_alu #(.DATA_W(DATA_W)) u_alu (
        .op  (in_op),
        .a   (in_a),
        .b   (in_b),
        .res (alu_res)
    );

    ieu_mul #(.DATA_W(DATA_W)) u_mul (
        .a       (in_a),
        .b       (in_b),
        .prod_lo (mul_res)
    );

    ieu_div #(.DATA_W(DATA_W)) u_div (
        .num (in_a),
        .den (in_b),
        .quo (div_res)
    );

    assign in_ready  = (st_q.cnt == '0);
    assign accept    = in_valid && in_ready;
    assign out_valid = st_q.vld;
    assign out_data  = st_q.res;
    assign out_tag   = st_q.tag;

    always_comb begin
        case (in_op)
            OP_MUL:  sel_res = mul_res;
            OP_DIV:  sel_res = div_res;
            default: sel_res = alu_res;
        endcase
        lat_sel = lat_of(in_op);

        st_d     = st_q;
        st_d.vld = 1'b0;
        if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
            if (st_q.cnt == CNT_W'(1)) st_d.vld = 1'b1;
        end else if (in_valid) begin
            st_d.res = sel_res;
            st_d.tag = in_tag;
            if (lat_sel <= CNT_W'(1)) st_d.vld = 1'b1;
            else                      st_d.cnt = lat_sel - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2 R3 R4 R10: a short operation answers in the next cycle
    assert_short_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && lat_of(in_op) <= CNT_W'(1)) |=> out_valid);

    // R8: accepting a long operation closes the input
    assert_busy_after_long_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && lat_of(in_op) > CNT_W'(1)) |=> !in_ready);

    // R8: ready only comes back together with the result
    assert_ready_with_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ready) |-> out_valid);

    // R9: no result is produced while the unit is busy
    assert_no_result_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> !out_valid);

    // R9: a short operation's result carries its own tag
    assert_tag_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(accept && lat_of(in_op) <= CNT_W'(1)))
            |-> (out_tag == $past(in_tag)));

    // R9: a result pulse lasts a single cycle unless a new short op follows
    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !accept) |=> !out_valid);

endmodule

// File: tb/sim_int_exec_unit.sv
module sim_int_exec_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_ready;
    logic [2:0]  in_op;
    logic [31:0] in_a, in_b;
    logic [4:0]  in_tag;
    logic        out_valid;
    logic [31:0] out_data;
    logic [4:0]  out_tag;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    int_exec_unit u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_tag(in_tag),
        .out_valid(out_valid), .out_data(out_data), .out_tag(out_tag)
    );

    function automatic logic [31:0] exp_res(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        logic lt, gt, eq;
        lt = $signed(a) < $signed(b);
        gt = $signed(a) > $signed(b);
        eq = (a == b);
        case (op)
            3'd0: exp_res = a + b;
            3'd1: exp_res = a & b;
            3'd2: exp_res = {29'd0, lt, gt, eq};
            3'd3: exp_res = a * b;
            3'd4: exp_res = (b == 32'd0) ? 32'hFFFF_FFFF : a / b;
            default: exp_res = 32'd0;
        endcase
    endfunction

    function automatic int exp_lat(input logic [2:0] op);
        if (op == 3'd3)      exp_lat = 6;
        else if (op == 3'd4) exp_lat = 19;
        else                 exp_lat = 1;
    endfunction

    function automatic string req_of(input logic [2:0] op, input logic [31:0] b);
        case (op)
            3'd0: req_of = "R2";
            3'd1: req_of = "R3";
            3'd2: req_of = "R4";
            3'd3: req_of = "R5";
            3'd4: req_of = (b == 32'd0) ? "R7" : "R6";
            default: req_of = "R10";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [4:0] tag);
        logic [31:0] e;
        int lat, n;
        string rq;
        e   = exp_res(op, a, b);
        lat = exp_lat(op);
        rq  = req_of(op, b);
        check(in_ready === 1'b1, "R8", "ready before issue", 32'(in_ready), 32'd1);
        in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_tag = tag;
        @(posedge clk); @(negedge clk);
        n = 1;
        while (out_valid !== 1'b1 && n < 40) begin
            check(in_ready === 1'b0, "R8", "ready while busy", 32'(in_ready), 32'd0);
            in_valid = 1'b1; in_op = 3'($urandom_range(0, 7));
            in_a = $urandom; in_b = $urandom; in_tag = ~tag;
            @(posedge clk); @(negedge clk);
            n++;
        end
        in_valid = 1'b0;
        check(n == lat, rq, "latency", 32'(n), 32'(lat));
        check(out_data === e, rq, "result", out_data, e);
        check(out_tag === tag, "R9", "tag", 32'(out_tag), 32'(tag));
        check(in_ready === 1'b1, "R8", "ready in result cycle", 32'(in_ready), 32'd1);
        @(posedge clk); @(negedge clk);
        check(out_valid === 1'b0, "R9", "single pulse, junk ignored", 32'(out_valid), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL R9 watchdog actual=hang expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [2:0]  sop [8];
        logic [31:0] sa  [8];
        logic [31:0] sb  [8];
        void'($urandom(32'd4242));
        rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_a = '0; in_b = '0; in_tag = '0;
        @(negedge clk);
        in_valid = 1'b1; in_op = 3'd4;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(out_valid === 1'b0, "R1", "valid in reset", 32'(out_valid), 32'd0);
        check(in_ready === 1'b1, "R1", "ready in reset", 32'(in_ready), 32'd1);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check(out_valid === 1'b0, "R1", "valid after reset", 32'(out_valid), 32'd0);
        check(in_ready === 1'b1, "R1", "ready after reset", 32'(in_ready), 32'd1);

        // directed corners
        do_op(3'd0, 32'hFFFF_FFFF, 32'd1, 5'd1);          // R2 wrap
        do_op(3'd0, 32'd1234, 32'd4321, 5'd2);            // R2
        do_op(3'd1, 32'hF0F0_1234, 32'h0FF0_FF00, 5'd3);  // R3
        do_op(3'd2, 32'hFFFF_FFFF, 32'd1, 5'd4);          // R4 less (signed)
        do_op(3'd2, 32'h7FFF_FFFF, 32'h8000_0000, 5'd5);  // R4 greater
        do_op(3'd2, 32'd77, 32'd77, 5'd6);                // R4 equal
        do_op(3'd3, 32'h0001_0000, 32'h0001_0000, 5'd7);  // R5 overflow
        do_op(3'd3, 32'd7, 32'd6, 5'd8);                  // R5
        do_op(3'd4, 32'd100, 32'd7, 5'd9);                // R6
        do_op(3'd4, 32'hFFFF_FFFF, 32'd1, 5'd10);         // R6
        do_op(3'd4, 32'd55, 32'd0, 5'd11);                // R7
        do_op(3'd0, 32'd3, 32'd4, 5'd12);                 // R7 accepts after zero divide
        do_op(3'd6, 32'd9, 32'd9, 5'd13);                 // R10
        do_op(3'd7, 32'hFFFF_FFFF, 32'd5, 5'd14);         // R10

        // R11: back-to-back single-cycle stream
        for (int k = 0; k < 8; k++) begin
            sop[k] = 3'(k % 3); sa[k] = $urandom; sb[k] = (k == 4) ? sa[k] : $urandom;
        end
        in_valid = 1'b1; in_op = sop[0]; in_a = sa[0]; in_b = sb[0]; in_tag = 5'd16;
        for (int k = 0; k < 8; k++) begin
            @(posedge clk); @(negedge clk);
            check(out_valid === 1'b1, "R11", "stream valid", 32'(out_valid), 32'd1);
            check(out_data === exp_res(sop[k], sa[k], sb[k]), "R11", "stream data",
                  out_data, exp_res(sop[k], sa[k], sb[k]));
            check(out_tag === 5'(16 + k), "R9", "stream tag", 32'(out_tag), 32'(16 + k));
            if (k < 7) begin
                in_op = sop[k+1]; in_a = sa[k+1]; in_b = sb[k+1]; in_tag = 5'(17 + k);
            end else begin
                in_valid = 1'b0;
            end
        end
        @(posedge clk); @(negedge clk);
        check(out_valid === 1'b0, "R9", "stream end", 32'(out_valid), 32'd0);

        // constrained random
        for (int i = 0; i < 120; i++) begin
            logic [2:0]  op;
            logic [31:0] a, b;
            op = 3'($urandom_range(0, 7));
            a  = $urandom;
            case ($urandom_range(0, 5))
                0: b = 32'd0;
                1: b = a;
                2: b = 32'($urandom_range(1, 300));
                default: b = $urandom;
            endcase
            do_op(op, a, b, 5'($urandom));
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule